// File: doc/BRIEF.md
# Register-Mapped System Timer Frame

This block is one frame of a system timer that sits on a simple 32-bit register bus. A free-running 64-bit system count comes in as an input. The frame reads that count out as two 32-bit words. From it the frame also derives a virtual count, which is the system count minus a 64-bit offset that software programs. The bus read path is combinational and stores nothing, so a value that crosses a word boundary between two reads can come back torn. Software deals with this by reading the high word again until two readings agree.

Two one-shot timers sit in the frame. The physical timer compares against the system count, and the virtual timer compares against the virtual count. Each timer holds an absolute 64-bit compare value. Software normally sets it through a signed 32-bit countdown view: a write adds the value to the current count, and a read returns how far away the compare point still is. When the count reaches the compare point, the timer's status bit stays set for as long as the timer is enabled. Each timer drives its own level interrupt output. Software silences that output with the mask bit and leaves the status alone.

Top module: `sys_timer_frame`

## Requirements
- R1: After reset, both timers are disabled and unmasked, both compare values and the virtual offset are zero, both interrupt outputs are low, and the virtual count reads equal to the system count.
- R2: A read at 0x00 or 0x04 returns the low or high word of the system count. A read at 0x08 or 0x0C returns the low or high word of the virtual count, which is the system count minus the offset. Every read shows the live value, and nothing is latched between the two word reads.
- R3: The virtual offset can be written and read back as a low word at 0x18 and a high word at 0x1C. A new offset changes the virtual count on the cycle after the write.
- R4: A write to a countdown register sets that timer's compare to its own count plus the sign-extended 32-bit write data. The physical countdown register is at 0x28 and the virtual one is at 0x38.
- R5: A read of a countdown register returns the low 32 bits of the timer's compare minus its current count.
- R6: Each control register uses bit 0 for enable, bit 1 for mask and bit 2 for status, and its other bits read as zero. The physical control register is at 0x2C and the virtual one is at 0x3C. Status is read-only, and writes to bit 2 are ignored.
- R7: Status reads 1 exactly when the timer is enabled and its count is greater than or equal to its compare, using an unsigned 64-bit comparison. The status stays set while the count keeps advancing.
- R8: Each interrupt output equals status AND enable AND NOT mask for its own timer. A fired timer does not affect the other timer's output.
- R9: Clearing enable brings status and the interrupt output low. The compare value and the mask are left unchanged.
- R10: A read at 0x10 returns the frequency parameter. Writes to 0x10 have no effect, and unmapped addresses read as zero.
- R11: Each compare value can be written and read directly as two words: the physical one at 0x20 and 0x24, the virtual one at 0x30 and 0x34.
- R12: The virtual timer fires on the virtual count. Raising the offset after the virtual timer has fired moves the virtual count back below the compare, and its status and interrupt go low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sys_count | input | 64 | Free-running system count |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| irq_phys | output | 1 | Physical timer level interrupt |
| irq_virt | output | 1 | Virtual timer level interrupt |

## Verification
Each timer is armed with a sweep of countdown values: the smallest and largest programmed delays, a mid-range delay, zero, and a negative delay. Each delay is tried from two base counts, one of which sits just below a 32-bit carry, so that both sign extension and the carry into the high word are tested. For every case the system count is set to one tick before the compare point, to the compare point itself, and to a point past it. This separates an off-by-one or signed comparison from the correct unsigned greater-or-equal. Mask, status-write and shutdown writes then separate the status bit from the interrupt output. Changing the count between the two word reads, and changing the offset after the virtual timer has fired, show that the read path is live and that the virtual timer follows the offset.

// File: rtl/sys_timer_frame.sv
module sys_timer_frame #(
  parameter int          ADDR_W  = 8,
  parameter logic [31:0] FREQ_HZ = 32'd24_000_000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [63:0]       sys_count,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic              irq_phys,
  output logic              irq_virt
);

  localparam logic [ADDR_W-1:0] A_PC_LO = ADDR_W'('h00);
  localparam logic [ADDR_W-1:0] A_PC_HI = ADDR_W'('h04);
  localparam logic [ADDR_W-1:0] A_VC_LO = ADDR_W'('h08);
  localparam logic [ADDR_W-1:0] A_VC_HI = ADDR_W'('h0C);
  localparam logic [ADDR_W-1:0] A_FREQ  = ADDR_W'('h10);
  localparam logic [ADDR_W-1:0] A_OF_LO = ADDR_W'('h18);
  localparam logic [ADDR_W-1:0] A_OF_HI = ADDR_W'('h1C);
  localparam int NT = 2;

  logic [63:0] voff, vcount;
  logic [63:0] cnt_w  [NT];
  logic [63:0] cmp_w  [NT];
  logic [31:0] tval_w [NT];
  logic [NT-1:0] en_w, msk_w, st_w, irq_w;

  assign vcount   = sys_count - voff;
  assign cnt_w[0] = sys_count;
  assign cnt_w[1] = vcount;
  assign irq_phys = irq_w[0];
  assign irq_virt = irq_w[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      voff <= '0;
    end else if (wr_en) begin
      if (addr == A_OF_LO) voff[31:0]  <= wdata;
      if (addr == A_OF_HI) voff[63:32] <= wdata;
    end
  end

  for (genvar t = 0; t < NT; t++) begin : g_tmr
    localparam logic [ADDR_W-1:0] A_CMP_LO = ADDR_W'(32 + 16 * t);
    localparam logic [ADDR_W-1:0] A_CMP_HI = ADDR_W'(36 + 16 * t);
    localparam logic [ADDR_W-1:0] A_TVAL   = ADDR_W'(40 + 16 * t);
    localparam logic [ADDR_W-1:0] A_CTL    = ADDR_W'(44 + 16 * t);

    logic [63:0] cmp_q;
    logic        en_q, msk_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cmp_q <= '0;
        en_q  <= 1'b0;
        msk_q <= 1'b0;
      end else if (wr_en) begin
        if (addr == A_CMP_LO) cmp_q[31:0]  <= wdata;
        if (addr == A_CMP_HI) cmp_q[63:32] <= wdata;
        if (addr == A_TVAL)   cmp_q <= cnt_w[t] + {{32{wdata[31]}}, wdata};
        if (addr == A_CTL) begin
          en_q  <= wdata[0];
          msk_q <= wdata[1];
        end
      end
    end

    logic [63:0] diff;
    assign diff      = cmp_q - cnt_w[t];
    assign cmp_w[t]  = cmp_q;
    assign tval_w[t] = diff[31:0];
    assign en_w[t]   = en_q;
    assign msk_w[t]  = msk_q;
    assign st_w[t]   = en_q && (cnt_w[t] >= cmp_q);
    assign irq_w[t]  = st_w[t] && !msk_q && en_q;

    // R9
    disable_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == A_CTL && !wdata[0]) |=> !irq_w[t]);

    // R8
    mask_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == A_CTL && wdata[1]) |=> !irq_w[t]);

    // R5
    tval_roundtrip_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == A_TVAL) |=>
        ((tval_w[t] == $past(wdata)) || (cnt_w[t] != $past(cnt_w[t]))));
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_PC_LO: rdata = sys_count[31:0];
      A_PC_HI: rdata = sys_count[63:32];
      A_VC_LO: rdata = vcount[31:0];
      A_VC_HI: rdata = vcount[63:32];
      A_FREQ:  rdata = FREQ_HZ;
      A_OF_LO: rdata = voff[31:0];
      A_OF_HI: rdata = voff[63:32];
      default: rdata = '0;
    endcase
    for (int t = 0; t < NT; t++) begin
      if (addr == ADDR_W'(32 + 16 * t)) rdata = cmp_w[t][31:0];
      if (addr == ADDR_W'(36 + 16 * t)) rdata = cmp_w[t][63:32];
      if (addr == ADDR_W'(40 + 16 * t)) rdata = tval_w[t];
      if (addr == ADDR_W'(44 + 16 * t)) rdata = {29'b0, st_w[t], msk_w[t], en_w[t]};
    end
  end

  // R3
  offset_applied_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_OF_LO && $stable(sys_count)) |=>
      (vcount[31:0] == $past(sys_count[31:0]) - $past(wdata)) || !$stable(sys_count));

endmodule

// File: tb/sys_timer_frame_test.sv
module sys_timer_frame_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] FREQ = 32'd24_000_000;

  logic        clk = 0;
  logic        rst_n = 0;
  logic [63:0] sys_count = 64'h0000_0123_4567_89AB;
  logic        wr_en = 0;
  logic [7:0]  addr = 0;
  logic [31:0] wdata = 0;
  logic [31:0] rdata;
  logic        irq_phys, irq_virt;

  int errors = 0;
  int checks = 0;

  sys_timer_frame #(.ADDR_W(8), .FREQ_HZ(FREQ)) uut (
    .clk(clk), .rst_n(rst_n), .sys_count(sys_count), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata),
    .irq_phys(irq_phys), .irq_virt(irq_virt));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic rd64(input logic [7:0] a, output logic [63:0] d);
    logic [31:0] lo, hi;
    rd(a, lo);
    rd(a + 8'h4, hi);
    d = {hi, lo};
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  function automatic logic irq_of(input int t);
    return (t == 0) ? irq_phys : irq_virt;
  endfunction

  initial begin
    logic [31:0] r;
    logic [63:0] r64, voff, base, cnt, cmp, sysv;
    logic [31:0] delays [5] = '{32'h0000_000F, 32'h0000_0100, 32'h7FFF_FFFF,
                                32'hFFFF_FFFB, 32'h0000_0000};
    logic [63:0] bases [2] = '{64'h00FF_FFFF_FFFF_FFF0, 64'h0000_0000_8000_0000};

    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 irq_phys", irq_phys, 0);
    chk("R1 irq_virt", irq_virt, 0);
    rd(8'h2C, r); chk("R1 pctl", r, 0);
    rd(8'h3C, r); chk("R1 vctl", r, 0);
    rd64(8'h20, r64); chk("R1 pcmp", r64, 0);
    rd64(8'h30, r64); chk("R1 vcmp", r64, 0);
    rd64(8'h18, r64); chk("R1 voff", r64, 0);
    rd64(8'h08, r64); chk("R1 vcount", r64, sys_count);
    rst_n = 1;
    @(negedge clk);

    // R10: frequency and unmapped
    rd(8'h10, r); chk("R10 freq", r, FREQ);
    wr(8'h10, 32'h1234_5678);
    rd(8'h10, r); chk("R10 freq write ignored", r, FREQ);
    rd(8'h14, r); chk("R10 unmapped", r, 0);
    rd(8'h40, r); chk("R10 unmapped", r, 0);

    // R2: live, unlatched count reads
    sys_count = 64'h0000_0005_FFFF_FFFF;
    rd(8'h00, r); chk("R2 pc lo", r, 32'hFFFF_FFFF);
    sys_count = 64'h0000_0006_0000_0000;
    rd(8'h04, r); chk("R2 pc hi live (torn)", r, 32'h6);
    rd(8'h00, r); chk("R2 pc lo live", r, 0);

    // R3: virtual offset
    voff = 64'h0000_0010_0000_0020;
    sys_count = 64'h0000_0123_0000_0010;
    wr(8'h18, voff[31:0]);
    wr(8'h1C, voff[63:32]);
    rd64(8'h18, r64); chk("R3 voff readback", r64, voff);
    rd64(8'h08, r64); chk("R2 vcount", r64, sys_count - voff);

    // R4..R9 sweep
    for (int t = 0; t < 2; t++) begin
      for (int b = 0; b < 2; b++) begin
        for (int i = 0; i < 5; i++) begin
          logic [7:0] ab;
          ab = (t == 0) ? 8'h20 : 8'h30;
          base = bases[b];
          sys_count = (t == 0) ? base : base + voff;
          wr(ab + 8'h08, delays[i]);
          cnt = base;
          cmp = cnt + {{32{delays[i][31]}}, delays[i]};
          rd64(ab, r64); chk("R4 compare from countdown", r64, cmp);
          rd(ab + 8'h08, r); chk("R5 countdown readback", r, delays[i]);
          wr(ab + 8'h0C, 32'h1);
          sysv = (t == 0) ? cmp - 1 : cmp - 1 + voff;
          sys_count = sysv; #1;
          rd(ab + 8'h0C, r); chk("R7 before compare", r, 32'h1);
          chk("R8 no irq before", irq_of(t), 0);
          sys_count = sysv + 1; #1;
          rd(ab + 8'h0C, r); chk("R7 at compare", r, 32'h5);
          chk("R8 irq at compare", irq_of(t), 1);
          chk("R8 other timer quiet", irq_of(1 - t), 0);
          sys_count = sysv + 6; #1;
          rd(ab + 8'h0C, r); chk("R7 sticky past compare", r, 32'h5);
          wr(ab + 8'h0C, 32'h3);
          rd(ab + 8'h0C, r); chk("R8 masked status kept", r, 32'h7);
          chk("R8 masked irq low", irq_of(t), 0);
          wr(ab + 8'h0C, 32'h5);
          rd(ab + 8'h0C, r); chk("R6 status write ignored", r, 32'h5);
          chk("R8 unmasked irq", irq_of(t), 1);
          wr(ab + 8'h0C, 32'h2);
          rd(ab + 8'h0C, r); chk("R9 shutdown ctl", r, 32'h2);
          chk("R9 shutdown irq", irq_of(t), 0);
          rd64(ab, r64); chk("R9 compare kept", r64, cmp);
          wr(ab + 8'h0C, 32'hFFFF_FFF8);
          rd(ab + 8'h0C, r); chk("R6 upper bits zero", r, 32'h0);
        end
      end
    end

    // R11: direct compare writes
    sys_count = 64'h0000_0200_0000_0000;
    wr(8'h20, 32'h0000_0005);
    wr(8'h24, 32'h0000_0200);
    rd64(8'h20, r64); chk("R11 pcmp direct", r64, 64'h0000_0200_0000_0005);
    wr(8'h2C, 32'h1);
    chk("R11 not yet", irq_phys, 0);
    sys_count = 64'h0000_0200_0000_0005; #1;
    chk("R11 fires on direct compare", irq_phys, 1);
    wr(8'h2C, 32'h0);

    // R12: virtual timer follows offset
    sys_count = 64'h0000_0300_0000_0000;
    wr(8'h38, 32'h0000_0100);
    cmp = sys_count - voff + 64'h100;
    rd64(8'h30, r64); chk("R12 vcmp", r64, cmp);
    wr(8'h3C, 32'h1);
    sys_count = sys_count + 64'h100; #1;
    chk("R12 virt fires", irq_virt, 1);
    chk("R12 phys quiet", irq_phys, 0);
    wr(8'h18, voff[31:0] + 32'h1);
    rd(8'h3C, r); chk("R12 status after offset raise", r, 32'h1);
    chk("R12 irq after offset raise", irq_virt, 0);

    finish_run();
  end
endmodule